// File: doc/BRIEF.md
# Digital potentiometer wiper controller

This block holds the wiper position of one digitally controlled potentiometer channel and drives the switch enables of its tap array. The wiper register is volatile. Out of reset it holds a fixed pre-recall tap, which depends on the channel type. Once the supply has stayed good for a programmed power-on reset time, the register loads the stored nonvolatile wiper value. After this recall, software can rewrite the position through a volatile write port. It can read the position back at any time on a dedicated output.

Whenever the wiper moves, the tap switches follow a make-before-break rule. The newly selected tap is enabled one clock before the old one is released. The resistor array and the nonvolatile cells sit outside the block. The stored value arrives as a plain input, and a nonvolatile write is performed by external logic, which captures the readback value.

The tap count is a parameter, with three supported channel types: 64, 100 and 256 taps. The pre-recall tap is derived from the tap count unless it is overridden.

Top module: `dcp_wiper_ctrl`

## Requirements
- R1: While rst_ni is low, tap_o holds the pre-recall tap and recall_done_o is 0. The pre-recall tap is 63 for 64 taps, 0 for 100 taps, 255 for 256 taps, and TAPS-1 otherwise.
- R2: Recall happens at the rising clock edge at which supply_ok_i has been sampled high on por_time_i+1 consecutive edges since reset. At that edge tap_o loads nv_tap_i, clamped to TAPS-1, and recall_done_o rises.
- R3: An edge that samples supply_ok_i low before recall restarts the consecutive count from zero.
- R4: Recall occurs once per reset. After recall_done_o is 1, it stays 1 until reset, and neither supply_ok_i nor nv_tap_i changes tap_o.
- R5: wr_en_i has no effect while recall_done_o is 0. This includes a write sampled at the very edge where recall happens, in which case the recalled value wins.
- R6: With recall_done_o at 1, a sampled wr_en_i loads wr_tap_i into tap_o at that edge. Values at or above TAPS are clamped to TAPS-1.
- R7: Bit i of tap_en_o enables tap i. In any cycle where tap_o did not change at the previous edge, exactly one bit is set: bit tap_o.
- R8: In the cycle after tap_o changes, exactly the old and the new tap bits are set (make-before-break). At the following edge the old bit drops if tap_o does not change again.
- R9: tap_o always equals the current wiper register value and is below TAPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supply above the first trip threshold |
| por_time_i | input | CW | Power-on reset time in clock cycles |
| nv_tap_i | input | W | Stored nonvolatile wiper value |
| wr_en_i | input | 1 | Volatile write strobe |
| wr_tap_i | input | W | Volatile write value |
| tap_en_o | output | TAPS | One-hot tap switch enables (two bits during overlap) |
| tap_o | output | W | Wiper register readback |
| recall_done_o | output | 1 | Wiper register holds a valid recalled or written value |

## Verification
Two events can fall on the same clock edge: the power-on recall and a volatile write. The bench holds wr_en_i high through the whole supply wait, including a ringing dropout that restarts the count. Every cycle it checks that the wiper stays at the pre-recall tap and that, at the recall edge, the nonvolatile value lands rather than the write value. The make-before-break overlap that this recall triggers is then judged from the two-bit enable pattern in that cycle. An exhaustive sweep of all write codes covers clamping and overlap.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic {
    RC_WAIT = 1'b0,
    RC_DONE = 1'b1
  } recall_st_e;

  // tap held before the stored value is recalled, per channel type
  function automatic int pre_recall_tap(int taps);
    case (taps)
      64:      return 63;
      100:     return 0;
      256:     return 255;
      default: return taps - 1;
    endcase
  endfunction

  function automatic int tap_width(int taps);
    return (taps <= 2) ? 1 : $clog2(taps);
  endfunction

endpackage

// File: rtl/dcp_por_timer.sv
module dcp_por_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          supply_ok_i,
  input  logic [CW-1:0] por_time_i,
  output logic          recall_o,
  output logic          done_o
);
  import dcp_pkg::*;

  logic [CW-1:0] cnt_q;
  recall_st_e    st_q;

  assign recall_o = (st_q == RC_WAIT) && supply_ok_i && (cnt_q >= por_time_i);
  assign done_o   = (st_q == RC_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      st_q  <= RC_WAIT;
    end else if (recall_o) begin
      cnt_q <= '0;
      st_q  <= RC_DONE;
    end else if (st_q == RC_WAIT) begin
      // any low sample restarts the wait
      cnt_q <= supply_ok_i ? cnt_q + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/dcp_wcr.sv
module dcp_wcr #(
  parameter int TAPS    = 64,
  parameter int W       = 6,
  parameter int PRE_TAP = 63
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         recall_i,
  input  logic [W-1:0] nv_tap_i,
  input  logic         wr_ok_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_tap_i,
  output logic [W-1:0] tap_o
);

  localparam logic [W-1:0] TopTap = W'(TAPS - 1);
  localparam logic [W-1:0] PreTap = W'(PRE_TAP);

  function automatic logic [W-1:0] clamp(logic [W-1:0] v);
    if (int'(v) >= TAPS) return TopTap;
    return v;
  endfunction

  logic [W-1:0] tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tap_q <= PreTap;
    else if (recall_i)          tap_q <= clamp(nv_tap_i);
    else if (wr_ok_i && wr_en_i) tap_q <= clamp(wr_tap_i);
  end

  assign tap_o = tap_q;

endmodule

// File: rtl/dcp_tap_mbb.sv
module dcp_tap_mbb #(
  parameter int TAPS    = 64,
  parameter int W       = 6,
  parameter int PRE_TAP = 63
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    tap_i,
  output logic [TAPS-1:0] en_o
);

  logic [W-1:0] old_q;
  logic         overlap;

  // old tap lags the register by one cycle; keeps it on across a move
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) old_q <= W'(PRE_TAP);
    else         old_q <= tap_i;
  end

  assign overlap = (old_q != tap_i);

  for (genvar g = 0; g < TAPS; g++) begin : g_sw
    assign en_o[g] = (tap_i == W'(g)) || (overlap && (old_q == W'(g)));
  end

endmodule

// File: rtl/dcp_wiper_ctrl.sv
module dcp_wiper_ctrl #(
  parameter int TAPS    = 64,
  parameter int PRE_TAP = dcp_pkg::pre_recall_tap(TAPS),
  parameter int CW      = 16,
  localparam int W      = dcp_pkg::tap_width(TAPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            supply_ok_i,
  input  logic [CW-1:0]   por_time_i,
  input  logic [W-1:0]    nv_tap_i,
  input  logic            wr_en_i,
  input  logic [W-1:0]    wr_tap_i,
  output logic [TAPS-1:0] tap_en_o,
  output logic [W-1:0]    tap_o,
  output logic            recall_done_o
);

  logic recall;
  logic done;

  dcp_por_timer #(.CW(CW)) u_por (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .por_time_i (por_time_i),
    .recall_o   (recall),
    .done_o     (done)
  );

  dcp_wcr #(.TAPS(TAPS), .W(W), .PRE_TAP(PRE_TAP)) u_wcr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .recall_i(recall),
    .nv_tap_i(nv_tap_i),
    .wr_ok_i (done),
    .wr_en_i (wr_en_i),
    .wr_tap_i(wr_tap_i),
    .tap_o   (tap_o)
  );

  dcp_tap_mbb #(.TAPS(TAPS), .W(W), .PRE_TAP(PRE_TAP)) u_mbb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tap_i (tap_o),
    .en_o  (tap_en_o)
  );

  assign recall_done_o = done;

endmodule

// File: rtl/dcp_wiper_chk.sv
module dcp_wiper_chk #(
  parameter int TAPS = 64,
  parameter int W    = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            supply_ok_i,
  input logic [W-1:0]    nv_tap_i,
  input logic            wr_en_i,
  input logic [W-1:0]    wr_tap_i,
  input logic [TAPS-1:0] tap_en_o,
  input logic [W-1:0]    tap_o,
  input logic            recall_done_o
);

  p_recall_needs_supply_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recall_done_o) |-> $past(supply_ok_i));

  p_recall_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recall_done_o) |->
      int'(tap_o) == ((int'($past(nv_tap_i)) >= TAPS) ? TAPS - 1 : int'($past(nv_tap_i))));

  p_done_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_done_o |=> recall_done_o);

  p_hold_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recall_done_o |=> (recall_done_o || $stable(tap_o)));

  p_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recall_done_o && wr_en_i) |=>
      int'(tap_o) == ((int'($past(wr_tap_i)) >= TAPS) ? TAPS - 1 : int'($past(wr_tap_i))));

  p_idle_no_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recall_done_o && !wr_en_i) |=> $stable(tap_o));

  p_single_tap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(tap_o) |-> ($countones(tap_en_o) == 1 && tap_en_o[tap_o]));

  p_mbb_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tap_o) |->
      ($countones(tap_en_o) == 2 && tap_en_o[tap_o] && tap_en_o[$past(tap_o)]));

  p_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tap_o) < TAPS);

endmodule

bind dcp_wiper_ctrl dcp_wiper_chk #(.TAPS(TAPS), .W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .supply_ok_i  (supply_ok_i),
  .nv_tap_i     (nv_tap_i),
  .wr_en_i      (wr_en_i),
  .wr_tap_i     (wr_tap_i),
  .tap_en_o     (tap_en_o),
  .tap_o        (tap_o),
  .recall_done_o(recall_done_o)
);

// File: tb/sim_dcp_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_dcp_wiper_ctrl;
  localparam int TAPS = 100;
  localparam int W    = 7;
  localparam int CW   = 8;
  localparam int POR  = 5;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            supply_ok_i = 1'b0;
  logic [CW-1:0]   por_time_i = CW'(POR);
  logic [W-1:0]    nv_tap_i = 7'd42;
  logic            wr_en_i = 1'b0;
  logic [W-1:0]    wr_tap_i = '0;
  logic [TAPS-1:0] tap_en_o;
  logic [W-1:0]    tap_o;
  logic            recall_done_o;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  always #2 clk_i = ~clk_i;

  dcp_wiper_ctrl #(.TAPS(TAPS), .CW(CW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i),
    .por_time_i(por_time_i), .nv_tap_i(nv_tap_i), .wr_en_i(wr_en_i),
    .wr_tap_i(wr_tap_i), .tap_en_o(tap_en_o), .tap_o(tap_o),
    .recall_done_o(recall_done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [TAPS-1:0] oh2(input int a, input int b);
    logic [TAPS-1:0] v;
    v = '0;
    v[a] = 1'b1;
    v[b] = 1'b1;
    return v;
  endfunction

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    int run;
    bit recalled;
    int prev;
    bit pat [14] = '{1, 1, 1, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};

    repeat (2) @(negedge clk_i);
    chk(tap_o == 0, "R1 pre-recall tap", tap_o, 0);
    chk(recall_done_o == 1'b0, "R1 done low", recall_done_o, 0);
    chk(tap_en_o == oh2(0, 0), "R7 reset enable", tap_en_o, oh2(0, 0));
    rst_ni = 1'b1;

    // supply ringing, with a write held on through the whole wait
    run = 0;
    recalled = 1'b0;
    for (int i = 0; i < 14; i++) begin
      supply_ok_i = pat[i];
      wr_en_i     = 1'b1;
      wr_tap_i    = 7'd7;
      step();
      if (pat[i]) begin
        if (run == POR) recalled = 1'b1;
        else run++;
      end else run = 0;
      if (recalled) begin
        chk(recall_done_o == 1'b1, "R2 recall edge", recall_done_o, 1);
        chk(tap_o == 42, "R5 recall wins over same-edge write", tap_o, 42);
        chk(tap_en_o == oh2(42, 0), "R8 overlap after recall", tap_en_o, oh2(42, 0));
        break;
      end else begin
        chk(recall_done_o == 1'b0, "R3 wait restarted", recall_done_o, 0);
        chk(tap_o == 0, "R5 write held off", tap_o, 0);
      end
    end
    chk(recalled, "R3 recall reached", 128'(recalled), 1);
    wr_en_i = 1'b0;
    step();
    chk(tap_en_o == oh2(42, 42), "R8 old tap released", tap_en_o, oh2(42, 42));
    chk(recall_done_o == 1'b1, "R2 done held", recall_done_o, 1);

    // exhaustive sweep of write codes
    prev = 42;
    for (int v = 0; v < 128; v++) begin
      int e;
      e = (v >= TAPS) ? TAPS - 1 : v;
      wr_tap_i = W'(v);
      wr_en_i  = 1'b1;
      step();
      wr_en_i = 1'b0;
      chk(tap_o == W'(e), "R6 write/clamp", tap_o, e);
      chk(tap_en_o == oh2(e, prev), "R8 make-before-break", tap_en_o, oh2(e, prev));
      step();
      chk(tap_en_o == oh2(e, e), "R7 single tap", tap_en_o, oh2(e, e));
      chk(tap_o == W'(e), "R9 readback", tap_o, e);
      prev = e;
    end

    // back-to-back writes
    wr_en_i  = 1'b1;
    wr_tap_i = 7'd10;
    step();
    wr_tap_i = 7'd20;
    step();
    wr_en_i = 1'b0;
    chk(tap_en_o == oh2(20, 10), "R8 back-to-back overlap", tap_en_o, oh2(20, 10));
    step();
    chk(tap_en_o == oh2(20, 20), "R7 after back-to-back", tap_en_o, oh2(20, 20));

    // supply loss and new stored value after recall
    supply_ok_i = 1'b0;
    nv_tap_i    = 7'd5;
    repeat (3) step();
    chk(recall_done_o == 1'b1, "R4 done sticky", recall_done_o, 1);
    chk(tap_o == 20, "R4 no re-recall on drop", tap_o, 20);
    supply_ok_i = 1'b1;
    repeat (8) step();
    chk(tap_o == 20, "R4 no re-recall on return", tap_o, 20);

    // fresh reset, zero wait time, out-of-range stored value
    por_time_i = '0;
    nv_tap_i   = 7'd120;
    rst_ni     = 1'b0;
    step();
    chk(tap_o == 0, "R1 reset again", tap_o, 0);
    chk(recall_done_o == 1'b0, "R1 done cleared", recall_done_o, 0);
    rst_ni = 1'b1;
    step();
    chk(recall_done_o == 1'b1, "R2 zero-time recall", recall_done_o, 1);
    chk(tap_o == 99, "R2 recall clamp", tap_o, 99);
    step();
    chk(tap_en_o == oh2(99, 99), "R7 after clamp recall", tap_en_o, oh2(99, 99));

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule